// File: doc/BRIEF.md
# Dual Wiper Register Controller

This block keeps the register state of a two-channel digital potentiometer and carries out instructions that an upstream serial parser has already decoded. Every channel owns one 8-bit wiper register, which sets the tap position, and a bank of four 8-bit data registers that hold stored settings. An instruction arrives as a one-cycle strobe with a 4-bit opcode, a 2-bit data-register select, a 2-bit channel select and a data byte. Supported operations are wiper and data-register writes and reads, single-channel and all-channel transfers in both directions, and a step mode.

In step mode the parser forwards one pulse for each fine-tuning clock. A direction bit comes with each pulse and moves the chosen wiper by one position. The wiper positions are always present on the output. A read answers one cycle later with a data byte and a valid strobe. Serial framing, nonvolatile storage and the resistor array are left to other blocks.

Top module: `dual_wiper_ctrl`

## Requirements
- R1: After reset, every wiper and data register holds 0x80 (mid-scale) and rd_valid is low.
- R2: The channel select picks channel 0 or 1. Wiper of channel 0 appears on wiper_pos[7:0] and channel 1 on wiper_pos[15:8]. Opcode 1010 loads instr_data into the selected wiper, visible the cycle after the strobe.
- R3: Opcode 1100 writes instr_data into data register instr_reg (0..3) of the selected channel. Opcode 1011 returns that register on rd_data with rd_valid high for exactly the cycle after the strobe.
- R4: Opcode 1001 returns the selected channel's wiper on rd_data with rd_valid, one cycle after the strobe.
- R5: Opcode 1101 copies data register instr_reg of the selected channel into that channel's wiper.
- R6: Opcode 1110 copies the selected channel's wiper into its data register instr_reg.
- R7: Opcode 0001 copies, for both channels at once, data register instr_reg into that channel's own wiper. The channel select is not used.
- R8: Opcode 1000 copies, for both channels at once, the wiper into that channel's data register instr_reg. The channel select is not used.
- R9: Opcode 0010 arms step mode for the selected channel. While armed, each step_pulse with step_up=1 raises that wiper by one and each with step_up=0 lowers it by one. The other channel is untouched. Any later accepted instruction disarms step mode.
- R10: Stepping saturates: a wiper at 0xFF does not go up and a wiper at 0x00 does not go down.
- R11: A channel select of 2 or 3 makes single-channel instructions (write, read, single transfer, step arm) have no effect: no register changes, no rd_valid, and step mode is not armed.
- R12: Opcodes 0000, 0011 to 0111 and 1111 change no register and raise no rd_valid, although they still disarm step mode.
- R13: When an instruction strobe and a step pulse fall in the same cycle, the instruction is executed and the step pulse is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | One-cycle strobe for a decoded instruction |
| instr_opcode | input | 4 | Instruction opcode |
| instr_reg | input | 2 | Data register select |
| instr_chan | input | 2 | Channel select |
| instr_data | input | 8 | Data byte for write instructions |
| step_pulse | input | 1 | One-cycle step request in step mode |
| step_up | input | 1 | Step direction, 1 raises the wiper |
| wiper_pos | output | 16 | Wiper positions, channel 1 in the upper byte |
| rd_valid | output | 1 | Read data valid strobe |
| rd_data | output | 8 | Read data |

## Verification
Two events can arrive in the same cycle: an instruction strobe and a step pulse aimed at an armed wiper. The bench arms step mode and then presents a read of the stepped wiper and a wiper write, each with a step pulse in the same cycle. A pass needs three results. The read must return the value from before the step. The write must leave exactly the written byte. A later lone pulse must have no effect, because the instruction disarmed step mode.

// File: rtl/dwc_pkg.sv
package dwc_pkg;
  localparam int OPC_W     = 4;
  localparam int CH_SEL_W  = 2;
  localparam int REG_SEL_W = 2;

  typedef enum logic [OPC_W-1:0] {
    OP_GANG_D2W = 4'b0001,
    OP_STEP     = 4'b0010,
    OP_GANG_W2D = 4'b1000,
    OP_RD_WCR   = 4'b1001,
    OP_WR_WCR   = 4'b1010,
    OP_RD_DR    = 4'b1011,
    OP_WR_DR    = 4'b1100,
    OP_D2W      = 4'b1101,
    OP_W2D      = 4'b1110
  } opcode_e;
endpackage

// File: rtl/dwc_rst_sync.sv
module dwc_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/dwc_decode.sv
module dwc_decode
  import dwc_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic                valid,
  input  logic [OPC_W-1:0]    op,
  input  logic [CH_SEL_W-1:0] chan,
  output logic [NUM_CH-1:0]   wr_wcr,
  output logic [NUM_CH-1:0]   wr_dr,
  output logic [NUM_CH-1:0]   d2w,
  output logic [NUM_CH-1:0]   w2d,
  output logic                rd_req,
  output logic                rd_sel_wcr,
  output logic                step_arm
);
  logic [NUM_CH-1:0] hit;
  logic              chan_ok;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
    assign hit[i] = (chan == CH_SEL_W'(i));
  end
  assign chan_ok = |hit;

  always_comb begin
    wr_wcr     = '0;
    wr_dr      = '0;
    d2w        = '0;
    w2d        = '0;
    rd_req     = 1'b0;
    rd_sel_wcr = 1'b0;
    step_arm   = 1'b0;
    if (valid) begin
      case (op)
        OP_WR_WCR:   wr_wcr = hit;
        OP_WR_DR:    wr_dr  = hit;
        OP_D2W:      d2w    = hit;
        OP_W2D:      w2d    = hit;
        OP_GANG_D2W: d2w    = '1;
        OP_GANG_W2D: w2d    = '1;
        OP_RD_WCR: begin
          rd_req     = chan_ok;
          rd_sel_wcr = 1'b1;
        end
        OP_RD_DR:    rd_req   = chan_ok;
        OP_STEP:     step_arm = chan_ok;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dwc_step.sv
module dwc_step
  import dwc_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                instr_valid,
  input  logic                step_arm,
  input  logic [CH_SEL_W-1:0] chan,
  input  logic                step_pulse,
  input  logic                step_up,
  output logic [NUM_CH-1:0]   inc,
  output logic [NUM_CH-1:0]   dec
);
  localparam int CH_IDX_W = $clog2(NUM_CH);

  logic                act_q, act_d;
  logic [CH_IDX_W-1:0] ch_q, ch_d;
  logic                st_en;
  logic                fire;

  always_comb begin
    st_en = instr_valid;
    act_d = act_q;
    ch_d  = ch_q;
    if (instr_valid) begin
      act_d = step_arm;
      ch_d  = chan[CH_IDX_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      ch_q  <= '0;
    end else if (st_en) begin
      act_q <= act_d;
      ch_q  <= ch_d;
    end
  end

  assign fire = act_q && step_pulse && !instr_valid;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_dir
    assign inc[i] = fire &&  step_up && (ch_q == CH_IDX_W'(i));
    assign dec[i] = fire && !step_up && (ch_q == CH_IDX_W'(i));
  end
endmodule

// File: rtl/dwc_channel.sv
module dwc_channel #(
  parameter int             DW      = 8,
  parameter int             NUM_DR  = 4,
  parameter logic [DW-1:0]  RST_VAL = {1'b1, {(DW-1){1'b0}}}
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_wcr,
  input  logic                       wr_dr,
  input  logic                       d2w,
  input  logic                       w2d,
  input  logic                       step_inc,
  input  logic                       step_dec,
  input  logic [$clog2(NUM_DR)-1:0]  rsel,
  input  logic [DW-1:0]              wdata,
  output logic [DW-1:0]              wcr,
  output logic [DW-1:0]              dr_rd
);
  localparam int RSEL_W = $clog2(NUM_DR);

  logic [DW-1:0]              wcr_q, wcr_d;
  logic                       wcr_en;
  logic [NUM_DR-1:0][DW-1:0]  dr_q, dr_d;
  logic [NUM_DR-1:0]          dr_en;

  always_comb begin
    wcr_en = 1'b0;
    wcr_d  = wcr_q;
    if (wr_wcr) begin
      wcr_en = 1'b1;
      wcr_d  = wdata;
    end else if (d2w) begin
      wcr_en = 1'b1;
      wcr_d  = dr_q[rsel];
    end else if (step_inc && (wcr_q != {DW{1'b1}})) begin
      wcr_en = 1'b1;
      wcr_d  = wcr_q + DW'(1);
    end else if (step_dec && (wcr_q != {DW{1'b0}})) begin
      wcr_en = 1'b1;
      wcr_d  = wcr_q - DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wcr_q <= RST_VAL;
    else if (wcr_en) wcr_q <= wcr_d;
  end

  for (genvar j = 0; j < NUM_DR; j++) begin : g_dr_next
    assign dr_en[j] = (wr_dr || w2d) && (rsel == RSEL_W'(j));
    assign dr_d[j]  = wr_dr ? wdata : wcr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < NUM_DR; j++) dr_q[j] <= RST_VAL;
    end else begin
      for (int j = 0; j < NUM_DR; j++) begin
        if (dr_en[j]) dr_q[j] <= dr_d[j];
      end
    end
  end

  assign wcr   = wcr_q;
  assign dr_rd = dr_q[rsel];
endmodule

// File: rtl/dual_wiper_ctrl.sv
module dual_wiper_ctrl
  import dwc_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int NUM_DR = 4,
  parameter int DW     = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   instr_valid,
  input  logic [OPC_W-1:0]       instr_opcode,
  input  logic [REG_SEL_W-1:0]   instr_reg,
  input  logic [CH_SEL_W-1:0]    instr_chan,
  input  logic [DW-1:0]          instr_data,
  input  logic                   step_pulse,
  input  logic                   step_up,
  output logic [NUM_CH*DW-1:0]   wiper_pos,
  output logic                   rd_valid,
  output logic [DW-1:0]          rd_data
);
  localparam int            RSEL_W   = $clog2(NUM_DR);
  localparam int            CH_IDX_W = $clog2(NUM_CH);
  localparam logic [DW-1:0] RST_VAL  = {1'b1, {(DW-1){1'b0}}};

  logic                rst_sync_n;
  logic [NUM_CH-1:0]   wr_wcr, wr_dr, d2w, w2d, inc, dec;
  logic                rd_req, rd_sel_wcr, step_arm;
  logic [DW-1:0]       wcr_arr [NUM_CH];
  logic [DW-1:0]       drr_arr [NUM_CH];
  logic [DW-1:0]       rd_d;
  logic                rd_en;
  logic                rd_valid_q;
  logic [DW-1:0]       rd_data_q;

  dwc_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  dwc_decode #(.NUM_CH(NUM_CH)) u_dec (
    .valid      (instr_valid),
    .op         (instr_opcode),
    .chan       (instr_chan),
    .wr_wcr     (wr_wcr),
    .wr_dr      (wr_dr),
    .d2w        (d2w),
    .w2d        (w2d),
    .rd_req     (rd_req),
    .rd_sel_wcr (rd_sel_wcr),
    .step_arm   (step_arm)
  );

  dwc_step #(.NUM_CH(NUM_CH)) u_step (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .instr_valid (instr_valid),
    .step_arm    (step_arm),
    .chan        (instr_chan),
    .step_pulse  (step_pulse),
    .step_up     (step_up),
    .inc         (inc),
    .dec         (dec)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    dwc_channel #(.DW(DW), .NUM_DR(NUM_DR), .RST_VAL(RST_VAL)) u_ch (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .wr_wcr   (wr_wcr[i]),
      .wr_dr    (wr_dr[i]),
      .d2w      (d2w[i]),
      .w2d      (w2d[i]),
      .step_inc (inc[i]),
      .step_dec (dec[i]),
      .rsel     (instr_reg[RSEL_W-1:0]),
      .wdata    (instr_data),
      .wcr      (wcr_arr[i]),
      .dr_rd    (drr_arr[i])
    );
    assign wiper_pos[i*DW +: DW] = wcr_arr[i];
  end

  always_comb begin
    rd_en = rd_req;
    rd_d  = rd_sel_wcr ? wcr_arr[instr_chan[CH_IDX_W-1:0]]
                       : drr_arr[instr_chan[CH_IDX_W-1:0]];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rd_valid_q <= 1'b0;
    else             rd_valid_q <= rd_req;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rd_data_q <= '0;
    else if (rd_en)  rd_data_q <= rd_d;
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;
endmodule

// File: rtl/dwc_checker.sv
module dwc_checker
  import dwc_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DW     = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  instr_valid,
  input logic [OPC_W-1:0]      instr_opcode,
  input logic [CH_SEL_W-1:0]   instr_chan,
  input logic [DW-1:0]         instr_data,
  input logic                  step_pulse,
  input logic [NUM_CH*DW-1:0]  wiper_pos,
  input logic                  rd_valid
);
  logic op_known, op_single, op_read;

  always_comb begin
    op_known  = 1'b0;
    op_single = 1'b0;
    op_read   = 1'b0;
    case (instr_opcode)
      OP_GANG_D2W, OP_GANG_W2D: op_known = 1'b1;
      OP_RD_WCR, OP_RD_DR: begin
        op_known = 1'b1; op_single = 1'b1; op_read = 1'b1;
      end
      OP_WR_WCR, OP_WR_DR, OP_D2W, OP_W2D, OP_STEP: begin
        op_known = 1'b1; op_single = 1'b1;
      end
      default: ;
    endcase
  end

  AST_WR_WIPER_CH0: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && instr_opcode == OP_WR_WCR && instr_chan == 2'd0
    |=> wiper_pos[DW-1:0] == $past(instr_data)); // R2

  AST_WR_WIPER_CH1: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && instr_opcode == OP_WR_WCR && instr_chan == 2'd1
    |=> wiper_pos[2*DW-1:DW] == $past(instr_data)); // R2

  AST_RD_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && op_read && instr_chan < CH_SEL_W'(NUM_CH) |=> rd_valid); // R3

  AST_NO_WRAP_CH0: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid && wiper_pos[DW-1:0] == {DW{1'b1}}
    |=> wiper_pos[DW-1:0] != {DW{1'b0}}); // R10

  AST_NO_WRAP_CH1: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid && wiper_pos[2*DW-1:DW] == {DW{1'b0}}
    |=> wiper_pos[2*DW-1:DW] != {DW{1'b1}}); // R10

  AST_BAD_CHAN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && op_single && instr_chan >= CH_SEL_W'(NUM_CH)
    |=> $stable(wiper_pos) && !rd_valid); // R11

  AST_UNKNOWN_OP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && !op_known |=> $stable(wiper_pos) && !rd_valid); // R12

  AST_INSTR_BEATS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && step_pulse && op_read |=> $stable(wiper_pos)); // R13
endmodule

bind dual_wiper_ctrl dwc_checker #(.NUM_CH(NUM_CH), .DW(DW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .instr_valid  (instr_valid),
  .instr_opcode (instr_opcode),
  .instr_chan   (instr_chan),
  .instr_data   (instr_data),
  .step_pulse   (step_pulse),
  .wiper_pos    (wiper_pos),
  .rd_valid     (rd_valid)
);

// File: tb/dual_wiper_ctrl_test.sv
module dual_wiper_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [3:0]  instr_opcode = '0;
  logic [1:0]  instr_reg = '0;
  logic [1:0]  instr_chan = '0;
  logic [7:0]  instr_data = '0;
  logic        step_pulse = 1'b0;
  logic        step_up = 1'b0;
  logic [15:0] wiper_pos;
  logic        rd_valid;
  logic [7:0]  rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dual_wiper_ctrl uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .instr_valid  (instr_valid),
    .instr_opcode (instr_opcode),
    .instr_reg    (instr_reg),
    .instr_chan   (instr_chan),
    .instr_data   (instr_data),
    .step_pulse   (step_pulse),
    .step_up      (step_up),
    .wiper_pos    (wiper_pos),
    .rd_valid     (rd_valid),
    .rd_data      (rd_data)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one instruction for one cycle; outputs are sampled on return
  task automatic issue(input logic [3:0] op, input logic [1:0] rs, input logic [1:0] ch,
                       input logic [7:0] d, input logic pulse = 1'b0, input logic up = 1'b0);
    @(negedge clk);
    instr_valid = 1'b1; instr_opcode = op; instr_reg = rs; instr_chan = ch; instr_data = d;
    step_pulse = pulse; step_up = up;
    @(negedge clk);
    instr_valid = 1'b0; step_pulse = 1'b0;
  endtask

  task automatic step(input logic up);
    @(negedge clk);
    step_pulse = 1'b1; step_up = up;
    @(negedge clk);
    step_pulse = 1'b0;
  endtask

  task automatic read_dr(input logic [1:0] ch, input logic [1:0] rs, input logic [7:0] exp,
                         input string tag);
    issue(4'b1011, rs, ch, 8'h00);
    check({tag, " rd_valid"}, rd_valid, 1);
    check({tag, " rd_data"}, rd_data, exp);
  endtask

  task automatic t_reset;
    check("R1 wipers mid-scale", wiper_pos, 16'h8080);
    check("R1 rd_valid low", rd_valid, 0);
    read_dr(2'd1, 2'd3, 8'h80, "R1 data reg reset");
  endtask

  task automatic t_write_read;
    issue(4'b1010, 2'd0, 2'd0, 8'h12);
    issue(4'b1010, 2'd0, 2'd1, 8'h34);
    check("R2 wiper writes", wiper_pos, 16'h3412);
    issue(4'b1001, 2'd0, 2'd1, 8'h00);
    check("R4 read wiper valid", rd_valid, 1);
    check("R4 read wiper data", rd_data, 8'h34);
    @(negedge clk);
    check("R3 rd_valid single cycle", rd_valid, 0);
    issue(4'b1100, 2'd2, 2'd0, 8'h5A);
    check("R3 data write leaves wiper", wiper_pos, 16'h3412);
    read_dr(2'd0, 2'd2, 8'h5A, "R3 data readback");
    read_dr(2'd0, 2'd1, 8'h80, "R3 neighbour register");
  endtask

  task automatic t_single_xfer;
    issue(4'b1101, 2'd2, 2'd0, 8'h00);
    check("R5 data to wiper", wiper_pos, 16'h345A);
    issue(4'b1110, 2'd1, 2'd1, 8'h00);
    read_dr(2'd1, 2'd1, 8'h34, "R6 wiper to data");
    read_dr(2'd0, 2'd1, 8'h80, "R6 other channel untouched");
  endtask

  task automatic t_gang;
    issue(4'b1100, 2'd3, 2'd0, 8'h11);
    issue(4'b1100, 2'd3, 2'd1, 8'h22);
    issue(4'b0001, 2'd3, 2'd3, 8'h00);
    check("R7 gang data to wiper", wiper_pos, 16'h2211);
    issue(4'b1000, 2'd0, 2'd2, 8'h00);
    issue(4'b1010, 2'd0, 2'd0, 8'h00);
    issue(4'b1010, 2'd0, 2'd1, 8'h00);
    read_dr(2'd0, 2'd0, 8'h11, "R8 gang wiper to data ch0");
    read_dr(2'd1, 2'd0, 8'h22, "R8 gang wiper to data ch1");
  endtask

  task automatic t_step;
    issue(4'b1010, 2'd0, 2'd1, 8'hFD);
    issue(4'b1010, 2'd0, 2'd0, 8'h40);
    issue(4'b0010, 2'd0, 2'd1, 8'h00);
    step(1'b1);
    check("R9 step up", wiper_pos, 16'hFE40);
    step(1'b1);
    step(1'b1);
    check("R10 saturate high", wiper_pos, 16'hFF40);
    step(1'b0);
    check("R9 step down", wiper_pos, 16'hFE40);
    issue(4'b1010, 2'd0, 2'd0, 8'h01);
    step(1'b0);
    check("R9 disarmed by instruction", wiper_pos, 16'hFE01);
    issue(4'b0010, 2'd0, 2'd0, 8'h00);
    step(1'b0);
    step(1'b0);
    check("R10 saturate low", wiper_pos, 16'hFE00);
  endtask

  task automatic t_bad_chan;
    issue(4'b1010, 2'd0, 2'd2, 8'h77);
    check("R11 write to absent channel", wiper_pos, 16'hFE00);
    issue(4'b1001, 2'd0, 2'd3, 8'h00);
    check("R11 read absent channel", rd_valid, 0);
    issue(4'b0010, 2'd0, 2'd2, 8'h00);
    step(1'b1);
    check("R11 step arm absent channel", wiper_pos, 16'hFE00);
  endtask

  task automatic t_unknown;
    issue(4'b0010, 2'd0, 2'd0, 8'h00);
    step(1'b1);
    check("R9 armed ch0", wiper_pos, 16'hFE01);
    issue(4'b0111, 2'd0, 2'd0, 8'h99);
    check("R12 unknown no change", wiper_pos, 16'hFE01);
    check("R12 unknown no read", rd_valid, 0);
    step(1'b1);
    check("R12 unknown disarms", wiper_pos, 16'hFE01);
    issue(4'b1111, 2'd1, 2'd1, 8'h99);
    issue(4'b0000, 2'd1, 2'd1, 8'h99);
    check("R12 opcodes 1111 and 0000", wiper_pos, 16'hFE01);
  endtask

  task automatic t_collision;
    issue(4'b0010, 2'd0, 2'd0, 8'h00);
    step(1'b1);
    check("R13 armed before collision", wiper_pos, 16'hFE02);
    issue(4'b1001, 2'd0, 2'd0, 8'h00, 1'b1, 1'b1);
    check("R13 read wins", rd_data, 8'h02);
    check("R13 step dropped", wiper_pos, 16'hFE02);
    step(1'b1);
    check("R13 read disarmed", wiper_pos, 16'hFE02);
    issue(4'b0010, 2'd0, 2'd0, 8'h00);
    issue(4'b1010, 2'd0, 2'd0, 8'hC3, 1'b1, 1'b0);
    check("R13 write exact", wiper_pos, 16'hFEC3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_write_read();
    t_single_xfer();
    t_gang();
    t_step();
    t_bad_chan();
    t_unknown();
    t_collision();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule